// File: doc/BRIEF.md
# Complementary Dead-Time Generator

This block turns one PWM status signal per channel into a complementary pair of output pins. On a rising edge of the status signal the complementary pin goes passive at once, and the primary pin only goes active after a programmable rise delay. On a falling edge the primary pin goes passive at once, and the complementary pin waits for a separate fall delay. Between the two transitions both pins stay passive, so the two sides of a half bridge are never driven at the same time.

There are two channels by default. Each has its own rise and fall counts, a channel-wide delay enable, separate enables for the direct and inverted paths, and a count-abort strobe. One shared prescaler divides the count clock by 1, 2, 4 or 8. Each pin has a bit that picks which path drives it and a bit that sets its passive level. A running bit per channel shows when a delay count is in progress.

Top module: `deadband_gen`

## Requirements
- R1: While rstN is low, every pin shows its passive level (pinOut equals passiveLvl) and every cntBusy bit is 0.
- R2: On a rising status edge with a nonzero rise count and both the channel and direct path enables set, the inverted path goes passive one cycle later. The direct path goes active after rise-count prescaled ticks, that is rise count + 1 cycles after the input change when the divide code is 0.
- R3: On a falling status edge with a nonzero fall count and both the channel and inverted path enables set, the direct path goes passive one cycle later. The inverted path goes active fall count + 1 cycles after the input change when the divide code is 0.
- R4: The direct and inverted paths of a channel are never active together. With outSel = 0 and passiveLvl = 0, pins 2c and 2c+1 are never both high.
- R5: A rise or fall count of zero adds no delay: the path becomes active one cycle after the input change, and cntBusy stays 0.
- R6: A new status edge while a count runs restarts the count with the value for the new edge. Both paths are passive in the cycle after that edge.
- R7: With chanEn[c] = 0, both transitions of channel c pass with no delay. With dirEn[c] = 0 the rise passes with no delay, and with invEn[c] = 0 the fall passes with no delay.
- R8: Divide code d on clkDiv makes the count advance once every 2^d cycles. Ticks fall on the cycles where the cycle count since reset release, taken modulo 2^d, equals 2^d - 1. A rise count N therefore completes between (N-1)*2^d + 2 and N*2^d + 1 cycles after the input change.
- R9: cntBusy[c] is 1 exactly while channel c holds a delay that is not yet complete.
- R10: A cntClr[c] pulse ends any count. In the next cycle cntBusy[c] is 0 and both paths follow the current status with no delay. This holds even when a status edge arrives in the same cycle, because the clear takes priority over the edge.
- R11: Pin 2c shows the direct path when outSel[2c] = 0 and the inverted path when it is 1. Pin 2c+1 shows the inverted path when outSel[2c+1] = 0 and the direct path when it is 1. The pin level is the path's active state XOR passiveLvl of that pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Synchronous reset, active low |
| stIn | input | NUM_CH | PWM status signal per channel |
| chanEn | input | NUM_CH | Channel-wide delay enable |
| dirEn | input | NUM_CH | Delay enable for the direct path |
| invEn | input | NUM_CH | Delay enable for the inverted path |
| riseVal | input | NUM_CH x DT_W | Rise delay count per channel |
| fallVal | input | NUM_CH x DT_W | Fall delay count per channel |
| clkDiv | input | DIV_W | Count clock divide code (2^code) |
| cntClr | input | NUM_CH | Strobe that aborts the channel's count |
| outSel | input | 2*NUM_CH | Path select per pin |
| passiveLvl | input | 2*NUM_CH | Passive level per pin |
| pinOut | output | 2*NUM_CH | Output pins, two per channel |
| cntBusy | output | NUM_CH | Count-running status per channel |

## Verification
Three events can land in the same cycle: a status edge, the expiry of a running count, and a count-abort strobe. The bench provokes all three. Directed cases place a clear in the same cycle as a falling edge, and toggle the status while a long count is still running. The random phase drives frequent toggles with small counts and changes the divide code, so new edges often meet count expiry. A cycle-level reference model in the bench judges every cycle, with the priority clear, then edge, then expiry.

// File: rtl/deadband_pkg.sv
package deadband_pkg;

  // Per-channel strobes from the control unit to the datapath.
  typedef struct packed {
    logic rise;   // status went 0 -> 1 this cycle
    logic fall;   // status went 1 -> 0 this cycle
    logic clr;    // abort the running count
    logic tick;   // prescaled count enable
  } chanStrobe_t;

endpackage

// File: rtl/deadband_ctrl.sv
module deadband_ctrl
  import deadband_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] stIn,
  input  logic [NUM_CH-1:0] cntClr,
  input  logic [DIV_W-1:0]  clkDiv,
  output chanStrobe_t       chStb [NUM_CH]
);

  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0]  divCnt;
  logic [PRE_W-1:0]  divMask;
  logic              tick;
  logic [NUM_CH-1:0] stPrev;

  // Free-running prescale counter; a tick fires when the low code bits are all ones.
  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + PRE_W'(1);
  end

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      divMask[i] = (32'(i) < 32'(clkDiv));
    end
    tick = &(divCnt | ~divMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) stPrev <= '0;
    else       stPrev <= stIn;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_stb
    assign chStb[c].rise = stIn[c] & ~stPrev[c];
    assign chStb[c].fall = ~stIn[c] & stPrev[c];
    assign chStb[c].clr  = cntClr[c];
    assign chStb[c].tick = tick;
  end

  // After a tick with a nonzero code, the low bits wrap, so no tick can follow directly.
  assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tick && clkDiv != '0) |=> (!tick || clkDiv == '0));

endmodule

// File: rtl/deadband_datapath.sv
module deadband_datapath
  import deadband_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DT_W   = 7
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CH-1:0]              stIn,
  input  chanStrobe_t                    chStb [NUM_CH],
  input  logic [NUM_CH-1:0]              chanEn,
  input  logic [NUM_CH-1:0]              dirEn,
  input  logic [NUM_CH-1:0]              invEn,
  input  logic [NUM_CH-1:0][DT_W-1:0]    riseVal,
  input  logic [NUM_CH-1:0][DT_W-1:0]    fallVal,
  input  logic [2*NUM_CH-1:0]            outSel,
  input  logic [2*NUM_CH-1:0]            passiveLvl,
  output logic [2*NUM_CH-1:0]            pinOut,
  output logic [NUM_CH-1:0]              cntBusy
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DT_W-1:0] cnt;
    logic            busy;
    logic            dirQ;
    logic            invQ;
    logic            riseDelay;
    logic            fallDelay;
    logic            actA;
    logic            actB;

    assign riseDelay = chanEn[c] && dirEn[c] && (riseVal[c] != '0);
    assign fallDelay = chanEn[c] && invEn[c] && (fallVal[c] != '0);

    // Priority: clear, then a new edge, then count expiry, else follow the status.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt  <= '0;
        busy <= 1'b0;
        dirQ <= 1'b0;
        invQ <= 1'b0;
      end else if (chStb[c].clr) begin
        cnt  <= '0;
        busy <= 1'b0;
        dirQ <= stIn[c];
        invQ <= ~stIn[c];
      end else if (chStb[c].rise) begin
        invQ <= 1'b0;
        if (riseDelay) begin
          dirQ <= 1'b0;
          busy <= 1'b1;
          cnt  <= riseVal[c];
        end else begin
          dirQ <= 1'b1;
          busy <= 1'b0;
          cnt  <= '0;
        end
      end else if (chStb[c].fall) begin
        dirQ <= 1'b0;
        if (fallDelay) begin
          invQ <= 1'b0;
          busy <= 1'b1;
          cnt  <= fallVal[c];
        end else begin
          invQ <= 1'b1;
          busy <= 1'b0;
          cnt  <= '0;
        end
      end else if (busy) begin
        if (chStb[c].tick) begin
          if (cnt == DT_W'(1)) begin
            cnt  <= '0;
            busy <= 1'b0;
            dirQ <= stIn[c];
            invQ <= ~stIn[c];
          end else begin
            cnt <= cnt - DT_W'(1);
          end
        end
      end else begin
        dirQ <= stIn[c];
        invQ <= ~stIn[c];
      end
    end

    assign actA = outSel[2*c]   ? invQ : dirQ;
    assign actB = outSel[2*c+1] ? dirQ : invQ;
    assign pinOut[2*c]   = actA ^ passiveLvl[2*c];
    assign pinOut[2*c+1] = actB ^ passiveLvl[2*c+1];
    assign cntBusy[c]    = busy;

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rstN)
      !(dirQ && invQ));

    assert_busy_count_R9: assert property (@(posedge clk) disable iff (!rstN)
      busy |-> (cnt != '0));

    assert_clear_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
      chStb[c].clr |=> !busy);

    assert_rise_inv_passive_R2: assert property (@(posedge clk) disable iff (!rstN)
      (chStb[c].rise && !chStb[c].clr) |=> !invQ);

    assert_fall_dir_passive_R3: assert property (@(posedge clk) disable iff (!rstN)
      (chStb[c].fall && !chStb[c].clr) |=> !dirQ);

    assert_zero_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
      (chStb[c].rise && !chStb[c].clr && riseVal[c] == '0) |=> (dirQ && !busy));
  end

endmodule

// File: rtl/deadband_gen.sv
module deadband_gen
  import deadband_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DT_W   = 7,
  parameter int DIV_W  = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CH-1:0]           stIn,
  input  logic [NUM_CH-1:0]           chanEn,
  input  logic [NUM_CH-1:0]           dirEn,
  input  logic [NUM_CH-1:0]           invEn,
  input  logic [NUM_CH-1:0][DT_W-1:0] riseVal,
  input  logic [NUM_CH-1:0][DT_W-1:0] fallVal,
  input  logic [DIV_W-1:0]            clkDiv,
  input  logic [NUM_CH-1:0]           cntClr,
  input  logic [2*NUM_CH-1:0]         outSel,
  input  logic [2*NUM_CH-1:0]         passiveLvl,
  output logic [2*NUM_CH-1:0]         pinOut,
  output logic [NUM_CH-1:0]           cntBusy
);

  chanStrobe_t chStb [NUM_CH];

  deadband_ctrl #(.NUM_CH(NUM_CH), .DIV_W(DIV_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .stIn   (stIn),
    .cntClr (cntClr),
    .clkDiv (clkDiv),
    .chStb  (chStb)
  );

  deadband_datapath #(.NUM_CH(NUM_CH), .DT_W(DT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stIn       (stIn),
    .chStb      (chStb),
    .chanEn     (chanEn),
    .dirEn      (dirEn),
    .invEn      (invEn),
    .riseVal    (riseVal),
    .fallVal    (fallVal),
    .outSel     (outSel),
    .passiveLvl (passiveLvl),
    .pinOut     (pinOut),
    .cntBusy    (cntBusy)
  );

endmodule

// File: tb/sim_deadband_gen.sv
`timescale 1ns/1ps
module sim_deadband_gen;

  logic            clk = 1'b0;
  logic            rstN;
  logic [1:0]      stIn, chanEn, dirEn, invEn, cntClr;
  logic [1:0][6:0] riseVal, fallVal;
  logic [1:0]      clkDiv;
  logic [3:0]      outSel, passiveLvl;
  logic [3:0]      pinOut;
  logic [1:0]      cntBusy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  deadband_gen u0 (
    .clk(clk), .rstN(rstN), .stIn(stIn), .chanEn(chanEn), .dirEn(dirEn),
    .invEn(invEn), .riseVal(riseVal), .fallVal(fallVal), .clkDiv(clkDiv),
    .cntClr(cntClr), .outSel(outSel), .passiveLvl(passiveLvl),
    .pinOut(pinOut), .cntBusy(cntBusy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit pinActive(input int p);
    return pinOut[p] ^ passiveLvl[p];
  endfunction

  // Reference model built from the requirements, stepped on each rising edge.
  int  mDiv;
  bit  mPrev [2];
  bit  mBusy [2];
  bit  mDir  [2];
  bit  mInv  [2];
  int  mCnt  [2];

  always @(posedge clk) begin
    if (!rstN) begin
      mDiv = 0;
      for (int c = 0; c < 2; c++) begin
        mPrev[c] = 0; mBusy[c] = 0; mDir[c] = 0; mInv[c] = 0; mCnt[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit tk, rs, fl;
        tk = (mDiv % (1 << clkDiv)) == ((1 << clkDiv) - 1);
        rs = stIn[c] && !mPrev[c];
        fl = !stIn[c] && mPrev[c];
        if (cntClr[c]) begin
          mBusy[c] = 0; mCnt[c] = 0; mDir[c] = stIn[c]; mInv[c] = !stIn[c];
        end else if (rs) begin
          mInv[c] = 0;
          if (chanEn[c] && dirEn[c] && riseVal[c] != 0) begin
            mDir[c] = 0; mBusy[c] = 1; mCnt[c] = int'(riseVal[c]);
          end else begin
            mDir[c] = 1; mBusy[c] = 0; mCnt[c] = 0;
          end
        end else if (fl) begin
          mDir[c] = 0;
          if (chanEn[c] && invEn[c] && fallVal[c] != 0) begin
            mInv[c] = 0; mBusy[c] = 1; mCnt[c] = int'(fallVal[c]);
          end else begin
            mInv[c] = 1; mBusy[c] = 0; mCnt[c] = 0;
          end
        end else if (mBusy[c]) begin
          if (tk) begin
            mCnt[c]--;
            if (mCnt[c] == 0) begin
              mBusy[c] = 0; mDir[c] = stIn[c]; mInv[c] = !stIn[c];
            end
          end
        end else begin
          mDir[c] = stIn[c]; mInv[c] = !stIn[c];
        end
        mPrev[c] = stIn[c];
      end
      mDiv++;
    end
  end

  // Cycle-by-cycle comparison against the model, sampled 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    if (!done) begin
      logic [3:0] expPins;
      logic [1:0] expBusy;
      for (int c = 0; c < 2; c++) begin
        bit a, b;
        a = outSel[2*c]   ? mInv[c] : mDir[c];
        b = outSel[2*c+1] ? mDir[c] : mInv[c];
        expPins[2*c]   = a ^ passiveLvl[2*c];
        expPins[2*c+1] = b ^ passiveLvl[2*c+1];
        expBusy[c]     = mBusy[c];
      end
      check(pinOut == expPins, "R2 R3 R7 R8 R11", "pins vs model", pinOut, expPins);
      check(cntBusy == expBusy, "R9", "busy vs model", cntBusy, expBusy);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic waitActive(input int p, output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!pinActive(p) && lat < 2000);
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    int lat;
    void'($urandom(32'd4242));
    rstN = 0; stIn = '0; chanEn = '1; dirEn = '1; invEn = '1; cntClr = '0;
    riseVal = '0; fallVal = '0; clkDiv = '0; outSel = '0; passiveLvl = 4'b0110;
    repeat (3) @(negedge clk);
    check(pinOut == 4'b0110, "R1", "pins in reset", pinOut, 4'b0110);
    check(cntBusy == 2'b00, "R1", "busy in reset", cntBusy, 0);
    passiveLvl = '0;
    rstN = 1;
    settle();

    // R2: rise delay of 5
    riseVal[0] = 7'd5; fallVal[0] = 7'd3;
    stIn[0] = 1;
    @(negedge clk);
    check(!pinActive(1), "R2", "inverted pin passive after rise", pinActive(1), 0);
    check(cntBusy[0] == 1, "R9", "busy during rise count", cntBusy[0], 1);
    lat = 1;
    while (!pinActive(0) && lat < 2000) begin @(negedge clk); lat++; end
    check(lat == 6, "R2", "rise latency", lat, 6);
    check(cntBusy[0] == 0, "R9", "idle after count", cntBusy[0], 0);
    settle();

    // R3: fall delay of 3
    stIn[0] = 0;
    @(negedge clk);
    check(!pinActive(0), "R3", "direct pin passive after fall", pinActive(0), 0);
    lat = 1;
    while (!pinActive(1) && lat < 2000) begin @(negedge clk); lat++; end
    check(lat == 4, "R3", "fall latency", lat, 4);
    settle();

    // R5: zero rise count
    riseVal[0] = 7'd0;
    stIn[0] = 1;
    waitActive(0, lat);
    check(lat == 1, "R5", "zero-count latency", lat, 1);
    check(cntBusy[0] == 0, "R5", "no busy with zero count", cntBusy[0], 0);
    stIn[0] = 0;
    settle();

    // R6: restart on toggle during a count
    riseVal[0] = 7'd20; fallVal[0] = 7'd4;
    stIn[0] = 1;
    repeat (3) @(negedge clk);
    stIn[0] = 0;
    @(negedge clk);
    check(!pinActive(0) && !pinActive(1), "R6", "both passive after restart",
          {pinActive(0), pinActive(1)}, 0);
    check(cntBusy[0] == 1, "R6", "busy after restart", cntBusy[0], 1);
    lat = 1;
    while (!pinActive(1) && lat < 2000) begin @(negedge clk); lat++; end
    check(lat == 5, "R6", "restarted fall latency", lat, 5);
    settle();

    // R7: channel and path enables
    riseVal[0] = 7'd9; fallVal[0] = 7'd9;
    chanEn[0] = 0;
    stIn[0] = 1;
    waitActive(0, lat);
    check(lat == 1, "R7", "channel disabled rise latency", lat, 1);
    stIn[0] = 0; settle();
    chanEn[0] = 1; dirEn[0] = 0;
    stIn[0] = 1;
    waitActive(0, lat);
    check(lat == 1, "R7", "direct path disabled latency", lat, 1);
    dirEn[0] = 1; invEn[0] = 0;
    stIn[0] = 0;
    waitActive(1, lat);
    check(lat == 1, "R7", "inverted path disabled latency", lat, 1);
    invEn[0] = 1;
    settle();

    // R8: divide by 4, rise count 3 -> between 10 and 13 cycles
    clkDiv = 2'd2; riseVal[0] = 7'd3;
    stIn[0] = 1;
    waitActive(0, lat);
    check(lat >= 10 && lat <= 13, "R8", "prescaled rise latency", lat, 10);
    stIn[0] = 0; clkDiv = 2'd0;
    settle();

    // R10: clear during a count
    riseVal[0] = 7'd30;
    stIn[0] = 1;
    repeat (2) @(negedge clk);
    cntClr[0] = 1;
    @(negedge clk);
    cntClr[0] = 0;
    check(cntBusy[0] == 0, "R10", "busy after clear", cntBusy[0], 0);
    check(pinActive(0) == 1, "R10", "direct active after clear", pinActive(0), 1);
    settle();
    // R10: clear in the same cycle as a falling edge
    fallVal[0] = 7'd30;
    stIn[0] = 0; cntClr[0] = 1;
    @(negedge clk);
    cntClr[0] = 0;
    check(cntBusy[0] == 0, "R10", "busy after clear with edge", cntBusy[0], 0);
    check(pinActive(1) == 1, "R10", "inverted active after clear with edge", pinActive(1), 1);
    settle();

    // R11: select and passive level on channel 1 (status low: inverted active)
    passiveLvl = 4'b0100;
    @(negedge clk);
    check(pinOut[2] == 1'b1, "R11", "high passive pin while passive", pinOut[2], 1);
    outSel = 4'b0100;
    @(negedge clk);
    check(pinOut[2] == 1'b0, "R11", "selected inverted path on pin 2", pinOut[2], 0);
    outSel = '0; passiveLvl = '0;
    settle();

    // R4: channel 1 with a delay, no overlap on pins 2 and 3
    riseVal[1] = 7'd6; fallVal[1] = 7'd2;
    for (int k = 0; k < 60; k++) begin
      if (k % 10 == 0) stIn[1] = ~stIn[1];
      @(negedge clk);
      check(!(pinOut[2] && pinOut[3]), "R4", "pins 2 and 3 overlap", pinOut[3:2], 0);
    end
    settle();

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      for (int c = 0; c < 2; c++) begin
        if ($urandom_range(5) == 0) stIn[c] = ~stIn[c];
        cntClr[c] = ($urandom_range(99) == 0);
      end
      if ($urandom_range(199) == 0) begin
        riseVal = {7'($urandom_range(12)), 7'($urandom_range(12))};
        fallVal = {7'($urandom_range(12)), 7'($urandom_range(12))};
        chanEn = 2'($urandom); dirEn = 2'($urandom); invEn = 2'($urandom);
        clkDiv = 2'($urandom);
        outSel = 4'($urandom); passiveLvl = 4'($urandom);
      end
      @(negedge clk);
    end
    cntClr = '0;
    settle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule